// File: doc/BRIEF.md
# Atomic Two-Byte Conversion Result Register

This block sits between an analog-to-digital converter and an 8-bit processor bus. It keeps the latest 10-bit conversion result and shows it to the bus as two read-only bytes: a low byte and a high byte. A single alignment input selects how the bits are placed. In right-adjusted placement the spare bits sit at the top of the high byte. In left-adjusted placement the top eight result bits fill the high byte. The alignment is applied when the bytes are read out, so changing it re-formats the stored value at once.

Reading a 10-bit value takes two bus reads, and a new conversion could complete between them. To keep the two bytes coherent, a low-byte read freezes the visible value until the matching high-byte read. Results that complete during that window wait in a single pending slot, and the newest one is kept. A high-byte read on its own never freezes anything, so software that only needs eight left-adjusted bits can poll the high byte. Differential conversions arrive in offset binary and are stored as two's complement. Single-ended conversions are stored as they arrive.

Top module: `adcreg_result`

## Requirements
- R1: With `align_left` low, `byte_lo` equals result bits 7:0, `byte_hi` bits 1:0 equal result bits 9:8, and `byte_hi` bits 7:2 read zero.
- R2: With `align_left` high, `byte_hi` equals result bits 9:2, `byte_lo` bits 7:6 equal result bits 1:0, and `byte_lo` bits 5:0 read zero.
- R3: A synchronous reset (`rst_n` low at a clock edge) clears the stored result to zero and removes any lock or pending result.
- R4: While unlocked, a result strobed by `conv_done` appears on the byte outputs from the cycle after the strobe.
- R5: A read strobe with `rd_sel` = 0 (low byte) locks the register. While it is locked, completed conversions leave both byte outputs unchanged.
- R6: A read strobe with `rd_sel` = 1 (high byte) while unlocked does not lock, and later conversions still appear at once.
- R7: When `conv_diff` is high, the stored value is the input with bit 9 inverted (offset binary to two's complement). When `conv_diff` is low, the input is stored unchanged.
- R8: Results that complete while locked go to a one-entry pending slot, and each newer result overwrites the older one. The high-byte read that releases the lock makes the pending value visible from the next cycle.
- R9: A change of `align_left` changes the byte outputs in the same cycle, with no new conversion.
- R10: A conversion strobed in the same cycle as the high-byte read that releases the lock is visible from the next cycle and takes precedence over a pending value.
- R11: A conversion strobed in the same cycle as a low-byte read is held pending. It does not alter the bytes being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| conv_done | input | 1 | One-cycle strobe: a new result is on `conv_data` |
| conv_data | input | 10 | Raw conversion result |
| conv_diff | input | 1 | The result comes from a differential conversion (offset binary) |
| align_left | input | 1 | 1 = left-adjusted placement, 0 = right-adjusted |
| rd_stb | input | 1 | Bus read strobe for one of the two bytes |
| rd_sel | input | 1 | Byte select for the read: 0 = low byte, 1 = high byte |
| byte_lo | output | 8 | Low data byte |
| byte_hi | output | 8 | High data byte |

## Verification
The bench aims at the ordering hazards. In the first, a conversion lands between the low-byte read and the high-byte read: a design with no interlock would return a high byte from a different sample. In the second, a conversion lands in the same cycle as the low-byte read: a design that checks only the registered lock state would let it through and tear the pair. In the third, a conversion lands in the same cycle as the releasing high-byte read: a design that gives the pending value priority would drop the newer result or show a stale one. The bench also polls the high byte alone to catch a design that locks on any read, and it strobes several results into one lock window to catch a pending slot that keeps the oldest result.

// File: rtl/adcreg_pkg.sv
// Package: shared encodings for the conversion result register.
// Assumes: the bus byte select is a single bit.
package adcreg_pkg;
    typedef enum logic {
        ALIGN_RIGHT = 1'b0,
        ALIGN_LEFT  = 1'b1
    } align_e;

    typedef enum logic {
        SEL_LOW  = 1'b0,
        SEL_HIGH = 1'b1
    } bytesel_e;
endpackage

// File: rtl/adcreg_fmt.sv
// Module: adcreg_fmt
// Converts a raw result into the stored, alignment-free form. Differential
// results arrive in offset binary; flipping the MSB makes two's complement.
// Assumes: RES_W >= 2.
module adcreg_fmt #(
    parameter int RES_W = 10
) (
    input  logic [RES_W-1:0] raw,
    input  logic             diff,
    output logic [RES_W-1:0] stored
);
    localparam int MSB = RES_W - 1;

    // Purpose: select unsigned or two's complement storage form.
    always_comb begin
        stored = raw;
        if (diff) stored[MSB] = ~raw[MSB];
    end
endmodule

// File: rtl/adcreg_lock.sv
// Module: adcreg_lock
// Holds the visible result, the low-then-high read interlock and a one-entry
// pending slot. Assumes: lo_rd and hi_rd are never high together.
module adcreg_lock #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_vld,
    input  logic [RES_W-1:0] conv_val,
    input  logic             lo_rd,
    input  logic             hi_rd,
    output logic [RES_W-1:0] vis
);
    logic             locked_q;
    logic             pend_vld_q;
    logic [RES_W-1:0] pend_q;
    logic [RES_W-1:0] vis_q;
    logic             release_now;
    logic             hold_now;

    // Purpose: classify the cycle as release, hold or free update.
    always_comb begin
        release_now = locked_q && hi_rd;
        hold_now    = (locked_q && !hi_rd) || (!locked_q && lo_rd);
    end

    // Purpose: update lock state, pending slot and visible result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q   <= 1'b0;
            pend_vld_q <= 1'b0;
            pend_q     <= '0;
            vis_q      <= '0;
        end else begin
            if (lo_rd)      locked_q <= 1'b1;
            else if (hi_rd) locked_q <= 1'b0;

            if (release_now) begin
                pend_vld_q <= 1'b0;
                if (conv_vld)        vis_q <= conv_val;
                else if (pend_vld_q) vis_q <= pend_q;
            end else if (hold_now) begin
                if (conv_vld) begin
                    pend_q     <= conv_val;
                    pend_vld_q <= 1'b1;
                end
            end else if (conv_vld) begin
                vis_q <= conv_val;
            end
        end
    end

    assign vis = vis_q;

    // R5: a locked cycle without a releasing read keeps the value.
    a_r5_frozen_while_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && !hi_rd) |=> $stable(vis_q));

    // R5: a low-byte read always leaves the register locked.
    a_r5_low_read_locks: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> locked_q);

    // R6: a high-byte read never leaves the register locked.
    a_r6_high_read_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rd |=> !locked_q);

    // R8: a release without a new strobe exposes the pending value.
    a_r8_pending_released: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && hi_rd && pend_vld_q && !conv_vld) |=> (vis_q == $past(pend_q)));

    // R10: a strobe that coincides with the release wins over pending data.
    a_r10_release_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && hi_rd && conv_vld) |=> (vis_q == $past(conv_val)));

    // R4: an unlocked, unread strobe is visible in the next cycle.
    a_r4_free_update: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_q && !lo_rd && conv_vld) |=> (vis_q == $past(conv_val)));
endmodule

// File: rtl/adcreg_view.sv
// Module: adcreg_view
// Splits the stored result into two bus bytes by alignment. Pure logic, so an
// alignment change shows in the same cycle.
// Assumes: BUS_W < RES_W <= 2*BUS_W.
module adcreg_view
    import adcreg_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int BUS_W = 8
) (
    input  logic [RES_W-1:0] vis,
    input  align_e           align,
    output logic [BUS_W-1:0] lo,
    output logic [BUS_W-1:0] hi
);
    localparam int SPILL = RES_W - BUS_W;
    localparam int PAD   = 2 * BUS_W - RES_W;

    logic [BUS_W-1:0] r_lo, r_hi, l_lo, l_hi;

    generate
        if (PAD > 0) begin : g_pad
            // Purpose: build both placements with zero fill.
            always_comb begin
                r_lo = vis[BUS_W-1:0];
                r_hi = {{PAD{1'b0}}, vis[RES_W-1:BUS_W]};
                l_hi = vis[RES_W-1 -: BUS_W];
                l_lo = {vis[SPILL-1:0], {PAD{1'b0}}};
            end
        end else begin : g_full
            // Purpose: full-width result, both placements coincide.
            always_comb begin
                r_lo = vis[BUS_W-1:0];
                r_hi = vis[RES_W-1:BUS_W];
                l_hi = r_hi;
                l_lo = r_lo;
            end
        end
    endgenerate

    // Purpose: choose the placement selected by the alignment input.
    always_comb begin
        if (align == ALIGN_LEFT) begin
            lo = l_lo;
            hi = l_hi;
        end else begin
            lo = r_lo;
            hi = r_hi;
        end
    end
endmodule

// File: rtl/adcreg_result.sv
// Module: adcreg_result (top)
// Conversion result register with two read-only bus bytes, selectable
// alignment and a low-then-high read interlock.
// Assumes: one byte read per cycle; conv_done is a one-cycle strobe.
module adcreg_result
    import adcreg_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic             conv_diff,
    input  logic             align_left,
    input  logic             rd_stb,
    input  logic             rd_sel,
    output logic [BUS_W-1:0] byte_lo,
    output logic [BUS_W-1:0] byte_hi
);
    logic [RES_W-1:0] stored;
    logic [RES_W-1:0] vis;
    logic             lo_rd, hi_rd;

    // Purpose: decode the bus strobe into per-byte read events.
    always_comb begin
        lo_rd = rd_stb && (bytesel_e'(rd_sel) == SEL_LOW);
        hi_rd = rd_stb && (bytesel_e'(rd_sel) == SEL_HIGH);
    end

    adcreg_fmt #(.RES_W(RES_W)) fmt_i (
        .raw    (conv_data),
        .diff   (conv_diff),
        .stored (stored)
    );

    adcreg_lock #(.RES_W(RES_W)) lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv_vld (conv_done),
        .conv_val (stored),
        .lo_rd    (lo_rd),
        .hi_rd    (hi_rd),
        .vis      (vis)
    );

    adcreg_view #(.RES_W(RES_W), .BUS_W(BUS_W)) view_i (
        .vis   (vis),
        .align (align_e'(align_left)),
        .lo    (byte_lo),
        .hi    (byte_hi)
    );
endmodule

// File: tb/adcreg_result_tb.sv
// Directed bench for adcreg_result: one task per scenario.
module adcreg_result_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic       conv_diff = 1'b0;
    logic       align_left = 1'b0;
    logic       rd_stb = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] byte_lo, byte_hi;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    adcreg_result dut_i (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .conv_diff(conv_diff), .align_left(align_left), .rd_stb(rd_stb),
        .rd_sel(rd_sel), .byte_lo(byte_lo), .byte_hi(byte_hi)
    );

    function automatic logic [15:0] model(input logic [9:0] r, input logic left);
        if (left) return {r[9:2], r[1:0], 6'b0};
        return {6'b0, r[9:8], r[7:0]};
    endfunction

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk_view(input string req, input logic [9:0] r);
        logic [15:0] e;
        e = model(r, align_left);
        n_chk++;
        if ({byte_hi, byte_lo} !== e) begin
            n_err++;
            $display("FAIL %s: actual %02h_%02h expected %02h_%02h",
                     req, byte_hi, byte_lo, e[15:8], e[7:0]);
        end
    endtask

    task automatic conv(input logic [9:0] d, input logic df);
        @(negedge clk);
        conv_done = 1'b1; conv_data = d; conv_diff = df;
        @(negedge clk);
        conv_done = 1'b0; conv_diff = 1'b0;
        #1;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        @(negedge clk);
        rd_stb = 1'b1; rd_sel = sel;
        #1 v = sel ? byte_hi : byte_lo;
        @(negedge clk);
        rd_stb = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk_view("R3 reset value", 10'h000);
        conv(10'h123, 1'b0);
        rd(1'b0, v);
        conv(10'h0F0, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1 chk_view("R3 reset clears value", 10'h000);
        conv(10'h05A, 1'b0);
        chk_view("R3 reset clears lock", 10'h05A);
    endtask

    task automatic t_right();
        align_left = 1'b0;
        conv(10'h2A5, 1'b0);
        chk8("R1 low byte", byte_lo, 8'hA5);
        chk8("R1 high byte", byte_hi, 8'h02);
        conv(10'h3FF, 1'b0);
        chk_view("R1 all ones", 10'h3FF);
        chk_view("R4 free update", 10'h3FF);
    endtask

    task automatic t_left();
        conv(10'h2A5, 1'b0);
        @(negedge clk); align_left = 1'b1;
        #1 chk8("R2 R9 high byte", byte_hi, 8'hA9);
        chk8("R2 R9 low byte", byte_lo, 8'h40);
        @(negedge clk); align_left = 1'b0;
        #1 chk_view("R9 back to right", 10'h2A5);
    endtask

    task automatic t_diff();
        conv(10'h2A5, 1'b1);
        chk_view("R7 diff positive", 10'h0A5);
        conv(10'h100, 1'b1);
        chk_view("R7 diff negative", 10'h300);
        conv(10'h2A5, 1'b0);
        chk_view("R7 single ended", 10'h2A5);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        conv(10'h155, 1'b0);
        rd(1'b0, v);
        chk8("R5 low read", v, 8'h55);
        conv(10'h0AA, 1'b0);
        chk_view("R5 frozen", 10'h155);
        rd(1'b1, v);
        chk8("R5 coherent high", v, 8'h01);
        chk_view("R8 pending shown", 10'h0AA);
    endtask

    task automatic t_newest();
        logic [7:0] v;
        rd(1'b0, v);
        conv(10'h011, 1'b0);
        conv(10'h022, 1'b0);
        chk_view("R5 frozen twice", 10'h0AA);
        rd(1'b1, v);
        chk8("R8 high before release", v, 8'h00);
        chk_view("R8 newest wins", 10'h022);
    endtask

    task automatic t_hi_only();
        logic [7:0] v;
        rd(1'b1, v);
        chk8("R6 high only", v, 8'h00);
        conv(10'h033, 1'b0);
        chk_view("R6 not locked", 10'h033);
    endtask

    task automatic t_same_release();
        logic [7:0] v;
        rd(1'b0, v);
        chk8("R10 low read", v, 8'h33);
        conv(10'h044, 1'b0);
        @(negedge clk);
        rd_stb = 1'b1; rd_sel = 1'b1; conv_done = 1'b1; conv_data = 10'h366;
        #1 v = byte_hi;
        chk8("R10 high returns old", v, 8'h00);
        @(negedge clk);
        rd_stb = 1'b0; conv_done = 1'b0;
        #1 chk_view("R10 release strobe wins", 10'h366);
    endtask

    task automatic t_same_lowread();
        logic [7:0] v;
        @(negedge clk);
        rd_stb = 1'b1; rd_sel = 1'b0; conv_done = 1'b1; conv_data = 10'h077;
        #1 v = byte_lo;
        chk8("R11 low returns old", v, 8'h66);
        @(negedge clk);
        rd_stb = 1'b0; conv_done = 1'b0;
        #1 chk_view("R11 deferred", 10'h366);
        rd(1'b1, v);
        chk8("R11 coherent high", v, 8'h03);
        chk_view("R11 shown after release", 10'h077);
    endtask

    initial begin
        t_reset();
        t_right();
        t_left();
        t_diff();
        t_lock();
        t_newest();
        t_hi_only();
        t_same_release();
        t_same_lowread();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule